// File: doc/BRIEF.md
# Regulator Fault and Enable Supervisor

This block is the digital sequencer for a synchronous buck controller. The analog front end delivers comparator flags that have already been digitized. The first pair of flags describes the input supply against two levels: a start level, which is the upper one, and a stop level, which is the lower one. The remaining flags report output overvoltage, high-side overcurrent and output undervoltage. The block also receives an active-high run enable and a 5-bit voltage-identification code. From these inputs it decides when the gate drivers may switch, when the soft-start capacitor is held shorted, and when the controller drops into its low-quiescent sleep state. It also drives the pull-down of an open-drain power-good pin.

The supply lockout uses hysteresis. A start flag enables operation, and only a stop flag ends it. Overvoltage and overcurrent each pass through a deglitch window of a configurable number of milliseconds, counted in clock ticks. A window that completes sets a sticky fault latch. That latch holds until the supply enters lockout. Neither the run enable nor the removal of the fault clears it. The identification code of all ones means that the output is switched off.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, drive_en_o=0, ss_discharge_o=1, sleep_o=1 and pg_pulldown_o=1.
- R2: The supply is accepted on the clock edge after supply_start_i is sampled high. It is dropped on the clock edge after supply_stop_i is sampled high. With neither flag high the supply state is held. With both flags high, the stop flag wins.
- R3: With run_en_i low, drive_en_o=0, ss_discharge_o=1 and sleep_o=1 one clock edge later.
- R4: A vid_i value of 5'b11111 gives the same outputs as R3 one clock edge later. Any other code allows operation.
- R5: When the supply state, run_en_i and vid_i all allow operation, ss_discharge_o falls on one edge and drive_en_o rises on the following edge. drive_en_o is never high while ss_discharge_o or sleep_o is high.
- R6: ovp_flag_i sampled high on DEGLITCH_TICKS consecutive edges sets the overvoltage latch on the last of those edges. On that same edge drive_en_o goes to 0 and ss_discharge_o goes to 1, while sleep_o stays 0.
- R7: ocp_flag_i behaves as in R6 through its own counter and latch.
- R8: A deglitch counter that sees its flag low returns to zero. A later assertion of the flag needs a full DEGLITCH_TICKS again.
- R9: A set fault latch keeps drive_en_o low, even when the flag falls and even when run_en_i toggles. Only a supply drop (R2) clears it. After the supply returns, normal sequencing resumes.
- R10: pg_pulldown_o=1 means that the power-good pin is pulled low. It equals out_low_i delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_start_i | input | 1 | Supply above start level |
| supply_stop_i | input | 1 | Supply below stop level |
| run_en_i | input | 1 | Run enable; low inhibits |
| vid_i | input | VID_W | Voltage-identification code |
| ovp_flag_i | input | 1 | Output overvoltage comparator |
| ocp_flag_i | input | 1 | High-side overcurrent comparator |
| out_low_i | input | 1 | Output undervoltage comparator |
| drive_en_o | output | 1 | Master enable for both gate drivers |
| ss_discharge_o | output | 1 | Short the soft-start capacitor |
| sleep_o | output | 1 | Low-quiescent state request |
| pg_pulldown_o | output | 1 | Pull the open-drain power-good pin low |

## Verification
The following properties are checked by assertions on every cycle:
- drive_en_o is never high together with sleep_o or soft-start discharge.
- An all-ones code or a stop flag forces the outputs off within a fixed number of edges.
- Fault latches only rise after a high flag and only fall through lockout.
- The power-good path tracks its input with a two-edge delay.

The following behaviours can only be shown by the bench's scenarios:
- The exact length of the deglitch window.
- A counter restarting after a flag dropout one tick short of the limit.
- Latch persistence across a run-enable toggle, and its release by a lockout cycle.
- The one-edge gap between the soft-start release and the driver enable.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int NUM_FAULTS = 2;
    localparam int OV_IDX     = 0;
    localparam int OC_IDX     = 1;

    typedef struct packed {
        logic drive_en;
        logic ss_dis;
        logic sleep;
    } seq_state_t;

endpackage

// File: rtl/sup_uvlo_hyst.sv
module sup_uvlo_hyst (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic stop_i,
    output logic ok_o
);
    typedef struct packed {
        logic ok;
    } uvlo_t;

    uvlo_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (stop_i) begin
            nxt_d.ok = 1'b0;
        end else if (start_i) begin
            nxt_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ok_o = cur_q.ok;

    // R2: the stop level always wins
    assert_stop_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !ok_o);

    // R2: with no flag, the state is held
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_i && !start_i) |=> $stable(ok_o));

endmodule

// File: rtl/sup_fault_deglitch.sv
module sup_fault_deglitch #(
    parameter int LIMIT = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flag_i,
    input  logic clear_i,
    output logic latched_o,
    output logic latch_nx_o
);
    localparam int            CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST_C = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          latched;
    } dgl_t;

    dgl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear_i) begin
            nxt_d.cnt     = '0;
            nxt_d.latched = 1'b0;
        end else begin
            if (!flag_i) begin
                nxt_d.cnt = '0;
            end else if (cur_q.cnt != LIM_C) begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
            if (flag_i && (cur_q.cnt == LAST_C)) begin
                nxt_d.latched = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign latched_o  = cur_q.latched;
    assign latch_nx_o = nxt_d.latched;

    // R8: the counter never runs past its limit
    assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.cnt <= LIM_C);

    // R8: a low flag restarts the window
    assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag_i) |=> (cur_q.cnt == '0));

    // R6: the latch only rises after a high flag
    assert_set_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(latched_o) |-> $past(flag_i));

    // R9: the latch stays set without a clear
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (latched_o && !clear_i) |=> latched_o);

endmodule

// File: rtl/sup_pg_sync.sv
module sup_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic low_i,
    output logic pulldown_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.sh = {cur_q.sh[STAGES-2:0], low_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pulldown_o = cur_q.sh[STAGES-1];

    // warm-up counter used only by the check below
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    generate
        if (STAGES == 2) begin : g_chk
            // R10: two-edge delay from the comparator flag to the pin
            assert_pg_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (warm_q == 2'd3) |-> (pulldown_o == $past(low_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
    import sup_pkg::*;
#(
    parameter int TICKS_PER_MS = 100000,
    parameter int DEGLITCH_MS  = 1,
    parameter int VID_W        = 5,
    parameter int PG_STAGES    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             supply_start_i,
    input  logic             supply_stop_i,
    input  logic             run_en_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             ovp_flag_i,
    input  logic             ocp_flag_i,
    input  logic             out_low_i,
    output logic             drive_en_o,
    output logic             ss_discharge_o,
    output logic             sleep_o,
    output logic             pg_pulldown_o
);
    localparam int DEGLITCH_TICKS = TICKS_PER_MS * DEGLITCH_MS;

    logic                  supply_ok;
    logic [NUM_FAULTS-1:0] flt_flag;
    logic [NUM_FAULTS-1:0] flt_lat;
    logic [NUM_FAULTS-1:0] flt_lat_nx;

    sup_uvlo_hyst u_uvlo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (supply_start_i),
        .stop_i  (supply_stop_i),
        .ok_o    (supply_ok)
    );

    assign flt_flag[OV_IDX] = ovp_flag_i;
    assign flt_flag[OC_IDX] = ocp_flag_i;

    generate
        for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_fault
            sup_fault_deglitch #(
                .LIMIT (DEGLITCH_TICKS)
            ) u_dgl (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .flag_i     (flt_flag[g]),
                .clear_i    (!supply_ok),
                .latched_o  (flt_lat[g]),
                .latch_nx_o (flt_lat_nx[g])
            );
        end
    endgenerate

    sup_pg_sync #(
        .STAGES (PG_STAGES)
    ) u_pg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .low_i      (out_low_i),
        .pulldown_o (pg_pulldown_o)
    );

    seq_state_t seq_q, seq_d;
    logic       vid_off;
    logic       ready;
    logic       fault_nx;

    always_comb begin
        vid_off         = &vid_i;
        ready           = supply_ok && run_en_i && !vid_off;
        fault_nx        = |flt_lat_nx;
        seq_d           = seq_q;
        seq_d.sleep     = !ready;
        seq_d.ss_dis    = !ready || fault_nx;
        seq_d.drive_en  = ready && !seq_q.ss_dis && !fault_nx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.drive_en <= 1'b0;
            seq_q.ss_dis   <= 1'b1;
            seq_q.sleep    <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drive_en_o     = seq_q.drive_en;
    assign ss_discharge_o = seq_q.ss_dis;
    assign sleep_o        = seq_q.sleep;

    // R3: drivers are off whenever the sleep state is requested
    assert_sleep_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_o |-> !drive_en_o);

    // R4: the all-ones code forces the sleep state
    assert_vid_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&vid_i) |=> (sleep_o && !drive_en_o));

    // R5: the soft-start release comes before the drivers start
    assert_ss_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drive_en_o) |-> $past(!ss_discharge_o));

    // R5: never drive while soft-start is shorted
    assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_en_o |-> !ss_discharge_o);

    // R6: a latched fault keeps the drivers off
    assert_fault_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|flt_lat) |-> !drive_en_o);

    // R2: a stop flag turns the drivers off two edges later
    assert_lockout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_stop_i |=> ##1 !drive_en_o);

endmodule

// File: tb/buck_fault_supervisor_tb_top.sv
module buck_fault_supervisor_tb_top;

    localparam int TPM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       run = 1'b0;
    logic [4:0] vid = 5'h05;
    logic       ov = 1'b0;
    logic       oc = 1'b0;
    logic       low = 1'b1;
    logic       drive_en, ss_dis, sleep, pg_pd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    buck_fault_supervisor #(
        .TICKS_PER_MS (TPM),
        .DEGLITCH_MS  (1),
        .VID_W        (5),
        .PG_STAGES    (2)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .supply_start_i (start),
        .supply_stop_i  (stop),
        .run_en_i       (run),
        .vid_i          (vid),
        .ovp_flag_i     (ov),
        .ocp_flag_i     (oc),
        .out_low_i      (low),
        .drive_en_o     (drive_en),
        .ss_discharge_o (ss_dis),
        .sleep_o        (sleep),
        .pg_pulldown_o  (pg_pd)
    );

    // expected field: {drive_en, ss_discharge, sleep, pg_pulldown}
    typedef struct packed {
        logic       start;
        logic       stop;
        logic       run;
        logic [4:0] vid;
        logic       ov;
        logic       oc;
        logic       low;
        logic [3:0] cyc;
        logic [3:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,5'h05,1'b0,1'b0,1'b1,4'd4,4'b0111,4'd2},  // R2 no start yet
        '{1'b1,1'b0,1'b1,5'h05,1'b0,1'b0,1'b0,4'd4,4'b1000,4'd5},  // R5 power up
        '{1'b0,1'b0,1'b1,5'h05,1'b0,1'b0,1'b0,4'd3,4'b1000,4'd2},  // R2 hold
        '{1'b0,1'b0,1'b0,5'h05,1'b0,1'b0,1'b0,4'd3,4'b0110,4'd3},  // R3 inhibit
        '{1'b0,1'b0,1'b1,5'h1F,1'b0,1'b0,1'b0,4'd3,4'b0110,4'd4},  // R4 code off
        '{1'b0,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd4,4'b1000,4'd4},  // R4 code on
        '{1'b0,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b1,4'd3,4'b1001,4'd10}, // R10 output low
        '{1'b0,1'b0,1'b1,5'h0A,1'b1,1'b0,1'b0,4'd5,4'b1000,4'd6},  // R6 short pulse
        '{1'b0,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd2,4'b1000,4'd8},  // R8 dropout
        '{1'b0,1'b0,1'b1,5'h0A,1'b1,1'b0,1'b0,4'd7,4'b1000,4'd8},  // R8 one short
        '{1'b0,1'b0,1'b1,5'h0A,1'b1,1'b0,1'b0,4'd2,4'b0100,4'd6},  // R6 trips
        '{1'b0,1'b0,1'b0,5'h0A,1'b0,1'b0,1'b0,4'd4,4'b0110,4'd9},  // R9 inhibit
        '{1'b0,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd4,4'b0100,4'd9},  // R9 still latched
        '{1'b0,1'b1,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd3,4'b0110,4'd9},  // R9 lockout
        '{1'b1,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd4,4'b1000,4'd9},  // R9 cleared
        '{1'b1,1'b0,1'b1,5'h0A,1'b0,1'b1,1'b0,4'd8,4'b0100,4'd7},  // R7 trips
        '{1'b1,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd3,4'b0100,4'd7},  // R7 sticky
        '{1'b0,1'b1,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd3,4'b0110,4'd2},  // R2 stop
        '{1'b1,1'b0,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd4,4'b1000,4'd9},  // R9 restart
        '{1'b1,1'b1,1'b1,5'h0A,1'b0,1'b0,1'b0,4'd3,4'b0110,4'd2}   // R2 stop wins
    };

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {drive_en, ss_dis, sleep, pg_pd};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b (drive,ss,sleep,pg)", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 4'b0111);               // R1 in reset
        rst_n = 1'b1;
        run   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", 4'b0111);               // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            start = VECS[i].start;
            stop  = VECS[i].stop;
            run   = VECS[i].run;
            vid   = VECS[i].vid;
            ov    = VECS[i].ov;
            oc    = VECS[i].oc;
            low   = VECS[i].low;
            repeat (int'(VECS[i].cyc)) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
        end

        // R5: exact sequencing edge by edge from lockout
        stop  = 1'b0;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 edge1", 4'b0110);
        @(posedge clk); @(negedge clk);
        chk("R5 edge2", 4'b0000);
        @(posedge clk); @(negedge clk);
        chk("R5 edge3", 4'b1000);

        // R10: two-edge latency of power-good
        low = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 edge1", 4'b1000);
        @(posedge clk); @(negedge clk);
        chk("R10 edge2", 4'b1001);
        low = 1'b0;

        // R6: exact window, one tick short then trip on the last tick
        ov = 1'b1;
        repeat (TPM - 1) @(posedge clk);
        @(negedge clk);
        chk("R6 limit-1", 4'b1000);
        @(posedge clk); @(negedge clk);
        chk("R6 limit", 4'b0100);
        ov = 1'b0;

        finish_run();
    end

endmodule